// File: doc/BRIEF.md
# Address Interlock Stall Counter

This block examines a stream of decoded instruction descriptors, at most one per clock, and reports for each accepted instruction how many extra stall cycles it costs and why. Five causes are scored: an address operand that depends on the previous instruction's result, a stack operation that follows an explicit write of the stack pointer, the use of an index register on the older core, a size prefix, and a plain register or flag dependency on the older core. A single mode input chooses between the older single-pipe timing and the dual-pipe timing.

Each descriptor names its address base and index registers, up to two source registers and one destination register, whether it reads or writes the flags, its stack-operation kind and a prefix count. Register identifiers name sub-registers, and the block folds every identifier onto its full 32-bit register before comparing. Only the last accepted instruction is remembered. The result appears one cycle after acceptance as a count plus a cause mask, so a performance model or trace tool can sum stalls or histogram their causes.

Top module: `stall_counter`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high in the following cycle with that instruction's count and causes; otherwise `out_valid`, `stall_cnt` and `stall_why` are all zero in the following cycle, and they are zero after reset.
- R2: If the base or index register of an instruction was the destination of the previous accepted instruction, one cycle is added and cause bit 0 is set, in both modes.
- R3: A register identifier is {part[1:0], num[2:0]}; part 2'b10 denotes a byte register whose num values 4 to 7 name the high byte of registers 0 to 3, every other part names register num; all dependency comparisons use the resulting full register.
- R4: A push (`stk_op` 2'b01) or pop (`stk_op` 2'b10) whose previous accepted instruction wrote register 4 (the stack pointer) as its destination and was not itself a stack operation costs one cycle, with cause bit 1 set.
- R5: A push or pop directly following another push or pop incurs no stack-pointer penalty.
- R6: With `core_mode` 0 (older core) an instruction using an index register costs one cycle, cause bit 2; with `core_mode` 1 (dual-pipe) index use costs nothing.
- R7: An instruction with a nonzero `pfx_cnt` costs exactly one cycle whatever the count, cause bit 3, in both modes.
- R8: With `core_mode` 0, reading a source register written by the previous accepted instruction, or reading the flags after the previous one wrote them, costs one cycle, cause bit 4; with `core_mode` 1 this costs nothing.
- R9: Cycles with `in_valid` low leave the remembered instruction unchanged, and reset clears it so the first instruction afterwards sees no dependency.
- R10: `stall_cnt` equals the number of cause bits set in `stall_why`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| core_mode | input | 1 | 0 older core, 1 dual-pipe core |
| base_id | input | 5 | Address base register identifier |
| base_use | input | 1 | Base register used |
| idx_id | input | 5 | Address index register identifier |
| idx_use | input | 1 | Index register used |
| src_a_id | input | 5 | First source register identifier |
| src_a_use | input | 1 | First source used |
| src_b_id | input | 5 | Second source register identifier |
| src_b_use | input | 1 | Second source used |
| dst_id | input | 5 | Destination register identifier |
| dst_use | input | 1 | Destination written |
| flags_rd | input | 1 | Instruction reads the flags |
| flags_wr | input | 1 | Instruction writes the flags |
| stk_op | input | 2 | 00 none, 01 push, 10 pop, 11 none |
| pfx_cnt | input | 2 | Number of size prefixes |
| out_valid | output | 1 | Result of the previous accepted instruction |
| stall_cnt | output | 3 | Extra stall cycles |
| stall_why | output | 5 | Cause mask: 0 address, 1 stack, 2 index, 3 prefix, 4 dependency |

## Verification
The bench builds the block with its default parameters: eight full registers, the stack pointer at register 4, a two-bit prefix count and a three-bit stall count. With eight registers the byte-register alias fold is reachable for both low and high bytes, including a high byte whose raw number collides with a different full register. The three-bit count covers the four-cause pile-up the bench drives, and both core modes are exercised against identical instruction pairs.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int CAUSE_N = 5;
  localparam int C_AGI = 0;
  localparam int C_STK = 1;
  localparam int C_IDX = 2;
  localparam int C_PFX = 3;
  localparam int C_DEP = 4;

  typedef enum logic [1:0] {
    STK_NONE = 2'b00,
    STK_PUSH = 2'b01,
    STK_POP  = 2'b10,
    STK_RSV  = 2'b11
  } stk_op_e;

  localparam logic [1:0] PART_BYTE = 2'b10;
endpackage

// File: rtl/stall_alias.sv
module stall_alias #(
  parameter int NUM_REGS = 8,
  parameter int NUM_W    = $clog2(NUM_REGS),
  parameter int ID_W     = NUM_W + 2
) (
  input  logic [ID_W-1:0]     id,
  input  logic                use_i,
  output logic [NUM_REGS-1:0] onehot
);
  import stall_pkg::*;

  localparam logic [NUM_W-1:0] HALF = NUM_W'(NUM_REGS / 2);

  logic [1:0]       part;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] full;

  assign part = id[ID_W-1 -: 2];
  assign num  = id[NUM_W-1:0];

  always_comb begin
    full = num;
    if (part == PART_BYTE && num >= HALF) full = num - HALF;
    onehot = '0;
    if (use_i) onehot[full] = 1'b1;
  end
endmodule

// File: rtl/stall_eval.sv
module stall_eval #(
  parameter int NUM_REGS = 8,
  parameter int SP_NUM   = 4,
  parameter int CNT_W    = 3
) (
  input  logic                          older_core,
  input  logic [NUM_REGS-1:0]           addr_mask,
  input  logic [NUM_REGS-1:0]           rd_mask,
  input  logic                          cur_flags_rd,
  input  logic                          cur_stack,
  input  logic                          cur_index,
  input  logic                          cur_prefixed,
  input  logic                          prev_valid,
  input  logic [NUM_REGS-1:0]           prev_wr_mask,
  input  logic                          prev_flags_wr,
  input  logic                          prev_stack,
  output logic [stall_pkg::CAUSE_N-1:0] why,
  output logic [CNT_W-1:0]              cnt
);
  import stall_pkg::*;

  always_comb begin
    why = '0;
    why[C_AGI] = prev_valid && (|(addr_mask & prev_wr_mask));
    why[C_STK] = prev_valid && cur_stack && prev_wr_mask[SP_NUM] && !prev_stack;
    why[C_IDX] = older_core && cur_index;
    why[C_PFX] = cur_prefixed;
    why[C_DEP] = older_core && prev_valid &&
                 ((|(rd_mask & prev_wr_mask)) || (cur_flags_rd && prev_flags_wr));
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < CAUSE_N; i++) cnt = cnt + CNT_W'(why[i]);
  end
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int NUM_REGS = 8,
  parameter int NUM_W    = $clog2(NUM_REGS),
  parameter int ID_W     = NUM_W + 2,
  parameter int SP_NUM   = 4,
  parameter int PFX_W    = 2,
  parameter int CNT_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          core_mode,
  input  logic [ID_W-1:0]               base_id,
  input  logic                          base_use,
  input  logic [ID_W-1:0]               idx_id,
  input  logic                          idx_use,
  input  logic [ID_W-1:0]               src_a_id,
  input  logic                          src_a_use,
  input  logic [ID_W-1:0]               src_b_id,
  input  logic                          src_b_use,
  input  logic [ID_W-1:0]               dst_id,
  input  logic                          dst_use,
  input  logic                          flags_rd,
  input  logic                          flags_wr,
  input  logic [1:0]                    stk_op,
  input  logic [PFX_W-1:0]              pfx_cnt,
  output logic                          out_valid,
  output logic [CNT_W-1:0]              stall_cnt,
  output logic [stall_pkg::CAUSE_N-1:0] stall_why
);
  import stall_pkg::*;

  localparam int N_IDS = 5;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // fold every register identifier onto its full register
  logic [ID_W-1:0]     ids   [N_IDS];
  logic                uses  [N_IDS];
  logic [NUM_REGS-1:0] masks [N_IDS];

  assign ids[0] = base_id;  assign uses[0] = base_use;
  assign ids[1] = idx_id;   assign uses[1] = idx_use;
  assign ids[2] = src_a_id; assign uses[2] = src_a_use;
  assign ids[3] = src_b_id; assign uses[3] = src_b_use;
  assign ids[4] = dst_id;   assign uses[4] = dst_use;

  for (genvar g = 0; g < N_IDS; g++) begin : g_alias
    stall_alias #(.NUM_REGS(NUM_REGS), .NUM_W(NUM_W), .ID_W(ID_W)) u_alias (
      .id     (ids[g]),
      .use_i  (uses[g]),
      .onehot (masks[g])
    );
  end

  logic [NUM_REGS-1:0] addr_mask, rd_mask, wr_mask;
  logic                cur_stack;

  assign addr_mask = masks[0] | masks[1];
  assign rd_mask   = masks[2] | masks[3];
  assign wr_mask   = masks[4];
  assign cur_stack = (stk_op == STK_PUSH) || (stk_op == STK_POP);

  // history of the last accepted instruction
  logic                prev_valid_q,   prev_valid_d;
  logic [NUM_REGS-1:0] prev_wr_q,      prev_wr_d;
  logic                prev_flags_q,   prev_flags_d;
  logic                prev_stack_q,   prev_stack_d;

  always_comb begin
    prev_valid_d = prev_valid_q;
    prev_wr_d    = prev_wr_q;
    prev_flags_d = prev_flags_q;
    prev_stack_d = prev_stack_q;
    if (in_valid) begin
      prev_valid_d = 1'b1;
      prev_wr_d    = wr_mask;
      prev_flags_d = flags_wr;
      prev_stack_d = cur_stack;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prev_valid_q <= 1'b0;
      prev_wr_q    <= '0;
      prev_flags_q <= 1'b0;
      prev_stack_q <= 1'b0;
    end else begin
      prev_valid_q <= prev_valid_d;
      prev_wr_q    <= prev_wr_d;
      prev_flags_q <= prev_flags_d;
      prev_stack_q <= prev_stack_d;
    end
  end

  // penalty scoring
  logic [CAUSE_N-1:0] why_c;
  logic [CNT_W-1:0]   cnt_c;

  stall_eval #(.NUM_REGS(NUM_REGS), .SP_NUM(SP_NUM), .CNT_W(CNT_W)) u_eval (
    .older_core    (!core_mode),
    .addr_mask     (addr_mask),
    .rd_mask       (rd_mask),
    .cur_flags_rd  (flags_rd),
    .cur_stack     (cur_stack),
    .cur_index     (idx_use),
    .cur_prefixed  (pfx_cnt != '0),
    .prev_valid    (prev_valid_q),
    .prev_wr_mask  (prev_wr_q),
    .prev_flags_wr (prev_flags_q),
    .prev_stack    (prev_stack_q),
    .why           (why_c),
    .cnt           (cnt_c)
  );

  // result register
  logic               out_valid_d;
  logic [CNT_W-1:0]   stall_cnt_d;
  logic [CAUSE_N-1:0] stall_why_d;

  always_comb begin
    out_valid_d = in_valid;
    stall_cnt_d = in_valid ? cnt_c : '0;
    stall_why_d = in_valid ? why_c : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
      stall_cnt <= '0;
      stall_why <= '0;
    end else begin
      out_valid <= out_valid_d;
      stall_cnt <= stall_cnt_d;
      stall_why <= stall_why_d;
    end
  end
endmodule

// File: rtl/stall_counter_chk.sv
module stall_counter_chk #(
  parameter int PFX_W = 2,
  parameter int CNT_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          core_mode,
  input logic                          idx_use,
  input logic [PFX_W-1:0]              pfx_cnt,
  input logic                          out_valid,
  input logic [CNT_W-1:0]              stall_cnt,
  input logic [stall_pkg::CAUSE_N-1:0] stall_why
);
  import stall_pkg::*;

  assert_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (stall_cnt == '0 && stall_why == '0));

  assert_dual_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(core_mode)) |-> (!stall_why[C_IDX] && !stall_why[C_DEP]));

  assert_index_older_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(core_mode)) |-> (stall_why[C_IDX] == $past(idx_use)));

  assert_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (stall_why[C_PFX] == ($past(pfx_cnt) != '0)));

  assert_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(stall_cnt) == $countones(stall_why)));
endmodule

bind stall_counter stall_counter_chk #(.PFX_W(PFX_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .core_mode (core_mode),
  .idx_use   (idx_use),
  .pfx_cnt   (pfx_cnt),
  .out_valid (out_valid),
  .stall_cnt (stall_cnt),
  .stall_why (stall_why)
);

// File: tb/stall_counter_test.sv
`timescale 1ns/1ps
module stall_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic       mode;
    logic [4:0] base; logic base_u;
    logic [4:0] idx;  logic idx_u;
    logic [4:0] sa;   logic sa_u;
    logic [4:0] sb;   logic sb_u;
    logic [4:0] dst;  logic dst_u;
    logic       frd;  logic fwr;
    logic [1:0] stk;
    logic [1:0] pfx;
  } desc_t;

  desc_t d;
  logic  vld;
  logic       out_valid;
  logic [2:0] stall_cnt;
  logic [4:0] stall_why;

  stall_counter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(vld), .core_mode(d.mode),
    .base_id(d.base), .base_use(d.base_u), .idx_id(d.idx), .idx_use(d.idx_u),
    .src_a_id(d.sa), .src_a_use(d.sa_u), .src_b_id(d.sb), .src_b_use(d.sb_u),
    .dst_id(d.dst), .dst_use(d.dst_u), .flags_rd(d.frd), .flags_wr(d.fwr),
    .stk_op(d.stk), .pfx_cnt(d.pfx),
    .out_valid(out_valid), .stall_cnt(stall_cnt), .stall_why(stall_why)
  );

  int total = 0;
  int bad = 0;

  // identifiers: {part, num}; part 0 full, 1 word, 2 byte
  localparam logic [4:0] EAX = 5'b00_000, ECX = 5'b00_001, EDX = 5'b00_010,
                         EBX = 5'b00_011, ESP = 5'b00_100, ESI = 5'b00_110,
                         EDI = 5'b00_111, CX = 5'b01_001, AH = 5'b10_100,
                         BH = 5'b10_111;

  task automatic blank(input logic mode);
    d = '0;
    d.mode = mode;
  endtask

  task automatic check(input string req, input logic [2:0] ecnt, input logic [4:0] ewhy,
                       input logic evld);
    total++;
    if (out_valid !== evld || stall_cnt !== ecnt || stall_why !== ewhy) begin
      bad++;
      $display("FAIL %s: got valid=%0b cnt=%0d why=%b, expected valid=%0b cnt=%0d why=%b",
               req, out_valid, stall_cnt, stall_why, evld, ecnt, ewhy);
    end
  endtask

  task automatic step(input string req, input logic [2:0] ecnt, input logic [4:0] ewhy);
    vld = 1'b1;
    @(posedge clk); @(negedge clk);
    check(req, ecnt, ewhy, 1'b1);
  endtask

  task automatic idle(input string req);
    vld = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req, 3'd0, 5'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 reset state", 3'd0, 5'b0, 1'b0);
    blank(1'b0); d.base = EAX; d.base_u = 1'b1; d.sa = EAX; d.sa_u = 1'b1; d.frd = 1'b1;
    step("R9 first after reset has no history", 3'd0, 5'b0);
    idle("R1 no input gives zero output");
  endtask

  task automatic t_agi;
    blank(1'b1); d.dst = EAX; d.dst_u = 1'b1;
    step("R2 producer", 3'd0, 5'b0);
    blank(1'b1); d.base = EAX; d.base_u = 1'b1;
    step("R2 base depends", 3'd1, 5'b00001);
    blank(1'b1); d.dst = ESI; d.dst_u = 1'b1;
    step("R2 producer 2", 3'd0, 5'b0);
    blank(1'b1); d.base = EBX; d.base_u = 1'b1; d.idx = ESI; d.idx_u = 1'b1;
    step("R2 index depends dual", 3'd1, 5'b00001);
    blank(1'b1); d.base = EBX; d.base_u = 1'b1;
    step("R2 unrelated base", 3'd0, 5'b0);
  endtask

  task automatic t_alias;
    blank(1'b1); d.dst = AH; d.dst_u = 1'b1;
    step("R3 write high byte", 3'd0, 5'b0);
    blank(1'b1); d.base = EAX; d.base_u = 1'b1;
    step("R3 high byte aliases reg 0", 3'd1, 5'b00001);
    blank(1'b1); d.dst = CX; d.dst_u = 1'b1;
    step("R3 write word", 3'd0, 5'b0);
    blank(1'b1); d.base = ECX; d.base_u = 1'b1;
    step("R3 word aliases reg 1", 3'd1, 5'b00001);
    blank(1'b1); d.dst = BH; d.dst_u = 1'b1;
    step("R3 write BH", 3'd0, 5'b0);
    blank(1'b1); d.base = EDI; d.base_u = 1'b1;
    step("R3 BH is not reg 7", 3'd0, 5'b0);
  endtask

  task automatic t_stack;
    blank(1'b1); d.dst = ESP; d.dst_u = 1'b1; d.fwr = 1'b1;
    step("R4 explicit sp update", 3'd0, 5'b0);
    blank(1'b1); d.stk = 2'b01; d.sa = EBX; d.sa_u = 1'b1;
    step("R4 push after sp update", 3'd1, 5'b00010);
    blank(1'b1); d.stk = 2'b01; d.sa = ECX; d.sa_u = 1'b1;
    step("R5 push after push", 3'd0, 5'b0);
    blank(1'b1); d.stk = 2'b10; d.dst = EDX; d.dst_u = 1'b1;
    step("R5 pop after push", 3'd0, 5'b0);
    blank(1'b1); d.stk = 2'b10; d.dst = ESI; d.dst_u = 1'b1;
    step("R5 pop after pop", 3'd0, 5'b0);
    blank(1'b1); d.dst = ESP; d.dst_u = 1'b1;
    step("R4 sp update again", 3'd0, 5'b0);
    blank(1'b1); d.stk = 2'b10; d.dst = EBX; d.dst_u = 1'b1;
    step("R4 pop after sp update", 3'd1, 5'b00010);
  endtask

  task automatic t_index;
    blank(1'b0);
    step("R6 spacer", 3'd0, 5'b0);
    blank(1'b0); d.base = EBX; d.base_u = 1'b1; d.idx = ESI; d.idx_u = 1'b1;
    step("R6 older index costs", 3'd1, 5'b00100);
    blank(1'b1); d.base = EBX; d.base_u = 1'b1; d.idx = ESI; d.idx_u = 1'b1;
    step("R6 dual index free", 3'd0, 5'b0);
  endtask

  task automatic t_prefix;
    blank(1'b1); d.pfx = 2'd1;
    step("R7 one prefix", 3'd1, 5'b01000);
    blank(1'b0); d.pfx = 2'd3;
    step("R7 three prefixes cost one", 3'd1, 5'b01000);
    blank(1'b1);
    step("R7 no prefix", 3'd0, 5'b0);
  endtask

  task automatic t_dep;
    blank(1'b0); d.dst = EAX; d.dst_u = 1'b1;
    step("R8 producer", 3'd0, 5'b0);
    blank(1'b0); d.sb = EAX; d.sb_u = 1'b1; d.fwr = 1'b1;
    step("R8 older register dep", 3'd1, 5'b10000);
    blank(1'b0); d.frd = 1'b1;
    step("R8 older flag dep", 3'd1, 5'b10000);
    blank(1'b1); d.dst = EDX; d.dst_u = 1'b1; d.fwr = 1'b1;
    step("R8 producer dual", 3'd0, 5'b0);
    blank(1'b1); d.sa = EDX; d.sa_u = 1'b1; d.frd = 1'b1;
    step("R8 dual dep free", 3'd0, 5'b0);
  endtask

  task automatic t_gap;
    blank(1'b0); d.dst = EDX; d.dst_u = 1'b1;
    step("R9 producer", 3'd0, 5'b0);
    blank(1'b0); d.dst = EBX; d.dst_u = 1'b1;
    idle("R9 bubble output");
    blank(1'b0); d.base = EDX; d.base_u = 1'b1;
    step("R9 history kept over bubble", 3'd1, 5'b00001);
  endtask

  task automatic t_sum;
    blank(1'b0); d.dst = EAX; d.dst_u = 1'b1; d.fwr = 1'b1;
    step("R10 producer", 3'd0, 5'b0);
    blank(1'b0); d.base = EAX; d.base_u = 1'b1; d.idx = ESI; d.idx_u = 1'b1;
    d.sa = EAX; d.sa_u = 1'b1; d.frd = 1'b1; d.pfx = 2'd2;
    step("R10 four causes", 3'd4, 5'b11101);
  endtask

  initial begin
    vld = 1'b0;
    d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_agi();
    t_alias();
    t_stack();
    t_index();
    t_prefix();
    t_dep();
    t_gap();
    t_sum();
    idle("R1 final idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: got running, expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule